// File: doc/BRIEF.md
# Protection Error Capture and Status

This block is the register-side companion of a memory protection unit that guards several slave ports. Each port's access checker raises a one-cycle violation strobe together with the 32-bit faulting address and an attribute word. For every port the block keeps an address capture register, an attribute capture register and a sticky error flag. Software clears a flag by writing a one to it. A control word also carries a global protection enable and read-only identification fields: a hardware revision, the number of slave ports, and a code for the number of region descriptors. The block drives only the enable to the region matching logic. While the enable is 0, that logic must allow every access from every bus master.

Software reaches the registers over a simple 32-bit bus. A write takes effect at the clock edge where `bus_wr_en` is high. A read is served by a two-state bus sequencer.

- `BUS_IDLE` moves to `BUS_RESP` when a read is requested.
- `BUS_RESP` stays in `BUS_RESP` on a new read request and otherwise returns to `BUS_IDLE`.

`bus_rd_valid` is high exactly while the sequencer is in `BUS_RESP`. The data it returns is the register content sampled at the request edge.

Register map (byte offsets):
- Control word at 0x000.
- Port n address capture at 0x100 + 8n.
- Port n attribute capture at 0x104 + 8n.

Top module: `prot_err_status`

## Requirements
- R1: Reset state.
  - The control word reads 0x0001_3201.
  - Its fields are: enable in bit 0 = 1; region-count code in bits [11:8] = 2 (code 0 = 8, 1 = 12, 2 = 16 descriptors); slave-port count in bits [15:12] = 3; revision in bits [19:16] = 1; error flags in bits [31:24] = 0.
  - All capture registers read 0.
- R2: A violation strobe on port n sets flag bit 24+n. In the same cycle it loads that port's address and attribute capture registers.
- R3: Writing the control word with a one in flag bit 24+n clears that flag. A zero in that bit leaves the flag unchanged.
- R4: If a violation on port n arrives in the same cycle as a clearing write to its flag, the flag remains set.
- R5: Every violation overwrites the port's capture registers, even while its flag is already set.
- R6: Control bit 0 is writable and drives `prot_enable` from the edge after the write.
- R7: Writes do not change the revision, port-count or region-count fields. Writes to capture register offsets are ignored.
- R8: Flag bits for port numbers at or above the implemented count (bits 27..31 with three ports) read 0, even after ones are written there.
- R9: A read request is answered on the next cycle with `bus_rd_valid` high and the data sampled at the request edge. Back-to-back requests give back-to-back responses. Unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr_en | input | 1 | Register write strobe |
| bus_rd_en | input | 1 | Register read request |
| bus_addr | input | REG_AW | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rd_valid | output | 1 | Read response valid |
| bus_rdata | output | 32 | Read response data |
| viol_valid | input | NUM_PORTS | Per-port violation strobe |
| viol_addr | input | NUM_PORTS*VA_W | Per-port faulting address, port n at [n*VA_W +: VA_W] |
| viol_attr | input | NUM_PORTS*ATTR_W | Per-port faulting attributes, port n at [n*ATTR_W +: ATTR_W] |
| prot_enable | output | 1 | Global protection enable to the region matcher |

## Verification
The bench builds the block with NUM_PORTS = 3, VA_W = 32, ATTR_W = 32, REV = 1 and REG_AW = 12. With three ports, five flag positions in the flag byte are unimplemented, which makes the read-as-zero rule observable. Full-width attributes let overwrite checks tell complete capture words apart. Two ports are struck in the same cycle as a clearing write, so both the set-wins rule and a flag outside the clear mask are seen in one response.

// File: rtl/pec_pkg.sv
package pec_pkg;

    typedef enum logic [0:0] {
        BUS_IDLE = 1'b0,
        BUS_RESP = 1'b1
    } bus_state_e;

    localparam int DATA_W      = 32;
    localparam int FLAG_LSB    = 24;
    localparam int FLAG_SLOTS  = 8;
    localparam int REV_LSB     = 16;
    localparam int NSP_LSB     = 12;
    localparam int NRG_LSB     = 8;
    localparam int EN_BIT      = 0;
    localparam int CAP_BASE    = 'h100;
    localparam int CAP_STRIDE  = 8;
    localparam int ATTR_OFS    = 4;
    localparam logic [3:0] REGION16_CODE = 4'd2;

endpackage

// File: rtl/pec_port_capture.sv
module pec_port_capture #(
    parameter int VA_W   = 32,
    parameter int ATTR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              viol,
    input  logic [VA_W-1:0]   v_addr,
    input  logic [ATTR_W-1:0] v_attr,
    input  logic              clr,
    output logic              flag,
    output logic [VA_W-1:0]   cap_addr,
    output logic [ATTR_W-1:0] cap_attr
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (viol) begin
            flag <= 1'b1;
        end else if (clr) begin
            flag <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_addr <= '0;
            cap_attr <= '0;
        end else if (viol) begin
            cap_addr <= v_addr;
            cap_attr <= v_attr;
        end
    end

    AST_FLAG_SET_ON_VIOL: assert property (@(posedge clk) disable iff (!rst_n) viol |=> flag); // R2
    AST_CLEAR_WHEN_QUIET: assert property (@(posedge clk) disable iff (!rst_n) (clr && !viol) |=> !flag); // R3
    AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) (clr && viol) |=> flag); // R4
    AST_ADDR_CAPTURED: assert property (@(posedge clk) disable iff (!rst_n) viol |=> (cap_addr == $past(v_addr))); // R5
    AST_ATTR_CAPTURED: assert property (@(posedge clk) disable iff (!rst_n) viol |=> (cap_attr == $past(v_attr))); // R2
    AST_CAPTURE_HELD: assert property (@(posedge clk) disable iff (!rst_n) !viol |=> ($stable(cap_addr) && $stable(cap_attr))); // R7

endmodule

// File: rtl/pec_ctrl_word.sv
module pec_ctrl_word
    import pec_pkg::*;
#(
    parameter int NUM_PORTS = 3,
    parameter int REV       = 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_ctrl,
    input  logic [DATA_W-1:0]    wdata,
    input  logic [NUM_PORTS-1:0] flags_in,
    output logic [NUM_PORTS-1:0] clr_vec,
    output logic                 prot_enable,
    output logic [DATA_W-1:0]    ctrl_word
);

    logic [FLAG_SLOTS-1:0] flag_byte;

    generate
        for (genvar s = 0; s < FLAG_SLOTS; s++) begin : g_slot
            if (s < NUM_PORTS) begin : g_impl
                assign flag_byte[s] = flags_in[s];
            end else begin : g_absent
                assign flag_byte[s] = 1'b0;
            end
        end
    endgenerate

    always_comb begin
        clr_vec = '0;
        if (wr_ctrl) begin
            clr_vec = wdata[FLAG_LSB +: NUM_PORTS];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prot_enable <= 1'b1;
        end else if (wr_ctrl) begin
            prot_enable <= wdata[EN_BIT];
        end
    end

    always_comb begin
        ctrl_word = '0;
        ctrl_word[FLAG_LSB +: FLAG_SLOTS] = flag_byte;
        ctrl_word[REV_LSB +: 4]          = 4'(REV);
        ctrl_word[NSP_LSB +: 4]          = 4'(NUM_PORTS);
        ctrl_word[NRG_LSB +: 4]          = REGION16_CODE;
        ctrl_word[EN_BIT]                = prot_enable;
    end

    AST_ENABLE_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!rst_n) wr_ctrl |=> (prot_enable == $past(wdata[EN_BIT]))); // R6
    AST_ENABLE_HELD: assert property (@(posedge clk) disable iff (!rst_n) !wr_ctrl |=> $stable(prot_enable)); // R6

endmodule

// File: rtl/pec_bus_fsm.sv
module pec_bus_fsm
    import pec_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_req,
    input  logic [DATA_W-1:0] rd_mux,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);

    bus_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= BUS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BUS_IDLE: if (rd_req) state_d = BUS_RESP;
            BUS_RESP: if (!rd_req) state_d = BUS_IDLE;
            default:  state_d = BUS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (rd_req) begin
            rd_data <= rd_mux;
        end
    end

    always_comb begin
        rd_valid = (state_q == BUS_RESP);
    end

    AST_RESP_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n) rd_req |=> rd_valid); // R9
    AST_NO_SPURIOUS_RESP: assert property (@(posedge clk) disable iff (!rst_n) !rd_req |=> !rd_valid); // R9
    AST_RESP_DATA: assert property (@(posedge clk) disable iff (!rst_n) rd_req |=> (rd_data == $past(rd_mux))); // R9

endmodule

// File: rtl/prot_err_status.sv
module prot_err_status
    import pec_pkg::*;
#(
    parameter int NUM_PORTS = 3,
    parameter int VA_W      = 32,
    parameter int ATTR_W    = 32,
    parameter int REV       = 1,
    parameter int REG_AW    = 12
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        bus_wr_en,
    input  logic                        bus_rd_en,
    input  logic [REG_AW-1:0]           bus_addr,
    input  logic [DATA_W-1:0]           bus_wdata,
    output logic                        bus_rd_valid,
    output logic [DATA_W-1:0]           bus_rdata,
    input  logic [NUM_PORTS-1:0]        viol_valid,
    input  logic [NUM_PORTS*VA_W-1:0]   viol_addr,
    input  logic [NUM_PORTS*ATTR_W-1:0] viol_attr,
    output logic                        prot_enable
);

    logic                 wr_ctrl;
    logic [NUM_PORTS-1:0] clr_vec;
    logic [NUM_PORTS-1:0] flags;
    logic [DATA_W-1:0]    ctrl_word;
    logic [DATA_W-1:0]    rd_mux;
    logic [VA_W-1:0]      cap_addr [NUM_PORTS];
    logic [ATTR_W-1:0]    cap_attr [NUM_PORTS];

    assign wr_ctrl = bus_wr_en && (bus_addr == '0);

    pec_ctrl_word #(
        .NUM_PORTS (NUM_PORTS),
        .REV       (REV)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_ctrl     (wr_ctrl),
        .wdata       (bus_wdata),
        .flags_in    (flags),
        .clr_vec     (clr_vec),
        .prot_enable (prot_enable),
        .ctrl_word   (ctrl_word)
    );

    generate
        for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
            pec_port_capture #(
                .VA_W   (VA_W),
                .ATTR_W (ATTR_W)
            ) u_cap (
                .clk      (clk),
                .rst_n    (rst_n),
                .viol     (viol_valid[p]),
                .v_addr   (viol_addr[p*VA_W +: VA_W]),
                .v_attr   (viol_attr[p*ATTR_W +: ATTR_W]),
                .clr      (clr_vec[p]),
                .flag     (flags[p]),
                .cap_addr (cap_addr[p]),
                .cap_attr (cap_attr[p])
            );
        end
    endgenerate

    always_comb begin
        rd_mux = '0;
        if (bus_addr == '0) begin
            rd_mux = ctrl_word;
        end
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (bus_addr == REG_AW'(CAP_BASE + p*CAP_STRIDE)) begin
                rd_mux = DATA_W'(cap_addr[p]);
            end
            if (bus_addr == REG_AW'(CAP_BASE + p*CAP_STRIDE + ATTR_OFS)) begin
                rd_mux = DATA_W'(cap_attr[p]);
            end
        end
    end

    pec_bus_fsm u_bus (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_req   (bus_rd_en),
        .rd_mux   (rd_mux),
        .rd_valid (bus_rd_valid),
        .rd_data  (bus_rdata)
    );

    AST_RO_FIELDS_FIXED: assert property (@(posedge clk) disable iff (!rst_n) $stable(ctrl_word[23:8])); // R7

endmodule

// File: tb/prot_err_status_bench.sv
module prot_err_status_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NP = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr_en = 1'b0;
    logic          bus_rd_en = 1'b0;
    logic [11:0]   bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic          bus_rd_valid;
    logic [31:0]   bus_rdata;
    logic [NP-1:0] viol_valid = '0;
    logic [NP*32-1:0] viol_addr = '0;
    logic [NP*32-1:0] viol_attr = '0;
    logic          prot_enable;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    logic [31:0] exp_q [$];
    string       tag_q [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    prot_err_status u_prot_err_status (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_wr_en    (bus_wr_en),
        .bus_rd_en    (bus_rd_en),
        .bus_addr     (bus_addr),
        .bus_wdata    (bus_wdata),
        .bus_rd_valid (bus_rd_valid),
        .bus_rdata    (bus_rdata),
        .viol_valid   (viol_valid),
        .viol_addr    (viol_addr),
        .viol_attr    (viol_attr),
        .prot_enable  (prot_enable)
    );

    // Monitor: pops expected responses as the design returns them.
    always @(negedge clk) begin
        if (rst_n && bus_rd_valid) begin
            n_checks++;
            if (exp_q.size() == 0) begin
                n_fail++;
                $display("FAIL unexpected response R9 actual=%h expected=none", bus_rdata);
            end else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (bus_rdata !== e) begin
                    n_fail++;
                    $display("FAIL %s actual=%h expected=%h", t, bus_rdata, e);
                end
            end
        end
    end

    task automatic step();
        @(negedge clk);
        bus_wr_en  = 1'b0;
        bus_rd_en  = 1'b0;
        viol_valid = '0;
    endtask

    task automatic set_rd(input logic [11:0] a, input logic [31:0] e, input string t);
        exp_q.push_back(e);
        tag_q.push_back(t);
        bus_rd_en = 1'b1;
        bus_addr  = a;
    endtask

    task automatic rd(input logic [11:0] a, input logic [31:0] e, input string t);
        set_rd(a, e, t);
        step();
    endtask

    task automatic set_wr(input logic [11:0] a, input logic [31:0] d);
        bus_wr_en = 1'b1;
        bus_addr  = a;
        bus_wdata = d;
    endtask

    task automatic set_viol(input int p, input logic [31:0] a, input logic [31:0] t);
        viol_valid[p] = 1'b1;
        viol_addr[p*32 +: 32] = a;
        viol_attr[p*32 +: 32] = t;
    endtask

    task automatic chk(input logic act, input logic ex, input string t);
        n_checks++;
        if (act !== ex) begin
            n_fail++;
            $display("FAIL %s actual=%b expected=%b", t, act, ex);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset contents
        chk(prot_enable, 1'b1, "R1 enable at reset");
        rd(12'h000, 32'h0001_3201, "R1 control word at reset");
        for (int p = 0; p < NP; p++) begin
            rd(12'(12'h100 + 8*p), 32'h0, "R1 address capture at reset");
            rd(12'(12'h104 + 8*p), 32'h0, "R1 attribute capture at reset");
        end

        // R2 first violation on port 1
        set_viol(1, 32'h2000_1000, 32'h0000_00A5);
        step();
        rd(12'h000, 32'h0201_3201, "R2 flag for port 1");
        rd(12'h108, 32'h2000_1000, "R2 address capture port 1");
        rd(12'h10C, 32'h0000_00A5, "R2 attribute capture port 1");

        // R5 overwrite while flag is set
        set_viol(1, 32'h4000_0FFC, 32'h8000_0003);
        step();
        rd(12'h108, 32'h4000_0FFC, "R5 address overwritten");
        rd(12'h10C, 32'h8000_0003, "R5 attribute overwritten");

        // R3 zero leaves flag, one clears it
        set_wr(12'h000, 32'h0000_0001);
        step();
        rd(12'h000, 32'h0201_3201, "R3 zero write keeps flag");
        set_wr(12'h000, 32'h0200_0001);
        step();
        rd(12'h000, 32'h0001_3201, "R3 one write clears flag");

        // R4 set wins over same-cycle clear; port 2 outside clear mask
        set_viol(0, 32'h1111_2220, 32'h0000_0011);
        set_viol(2, 32'h3333_4440, 32'h0000_0022);
        set_wr(12'h000, 32'h0100_0001);
        step();
        rd(12'h000, 32'h0501_3201, "R4 flag kept on same-cycle clear");
        rd(12'h100, 32'h1111_2220, "R2 address capture port 0");
        rd(12'h114, 32'h0000_0022, "R2 attribute capture port 2");

        // R6 R7 R8 write all ones except enable
        set_wr(12'h000, 32'hFFFF_FFFE);
        step();
        chk(prot_enable, 1'b0, "R6 enable cleared by write");
        rd(12'h000, 32'h0001_3200, "R7 R8 read-only fields and absent flags");

        // R7 writes to capture offsets ignored
        set_wr(12'h100, 32'hDEAD_BEEF);
        step();
        set_wr(12'h104, 32'hCAFE_F00D);
        step();
        rd(12'h100, 32'h1111_2220, "R7 address capture write ignored");
        rd(12'h104, 32'h0000_0011, "R7 attribute capture write ignored");

        // R9 back-to-back and unmapped offsets
        set_rd(12'h040, 32'h0, "R9 unmapped offset");
        @(negedge clk);
        set_rd(12'h110, 32'h3333_4440, "R9 back-to-back second");
        @(negedge clk);
        set_rd(12'h118, 32'h0, "R9 offset beyond last port");
        step();

        // R6 re-enable
        set_wr(12'h000, 32'h0000_0001);
        step();
        chk(prot_enable, 1'b1, "R6 enable set by write");
        rd(12'h000, 32'h0001_3201, "R6 control word after re-enable");

        repeat (4) step();
        n_checks++;
        if (exp_q.size() != 0) begin
            n_fail++;
            $display("FAIL R9 missing responses actual=%0d expected=0", exp_q.size());
        end
        summary();
    end

endmodule